// File: doc/BRIEF.md
# Indexed widening quad-lane multiply-accumulate

This block performs one step of a matrix-style outer-product accumulation. A source vector of narrow signed elements is multiplied by a single signed element taken from a second vector. The multiplier element is picked by an index, separately inside every 128-bit segment. Each product is widened and added to one of four accumulator rows. Narrow element `4e+i` of the source feeds wide element `e` of row `i`. The four rows therefore together consume all four interleaved narrow lanes that sit under each wide element.

Two element sizes are selected by a mode pin: signed bytes accumulating into 32-bit elements, or signed halfwords accumulating into 64-bit elements. The result is registered and offered on a valid/ready output. A new operation is accepted only when the output register is empty, or when it is being drained in the same cycle. While the output is stalled, the result holds steady and the input is refused.

Top module: `qmac_quad`

## Requirements
- R1: With `mode`=0, the narrow elements are signed 8-bit and the accumulator elements are 32-bit. With `mode`=1, the narrow elements are signed 16-bit and the accumulator elements are 64-bit.
- R2: Row `i` occupies `acc_in`/`acc_out` bits `[i*VL +: VL]`, and wide element `e` occupies the low-first slice `e` of its row. The first operand for row `i`, element `e` is narrow element `4e+i` of `src_a`, where narrow element 0 is the least significant.
- R3: The second operand for wide element `e` is narrow element `idx` of the 128-bit segment of `src_b` that holds element `e`. Segment `s` is bits `[128s +: 128]`.
- R4: `idx` selects 0–15 in byte mode and 0–7 in halfword mode. In halfword mode `idx[3]` has no effect.
- R5: Both operands are signed two's complement, and the product is sign-extended to the wide element size.
- R6: The sum of the accumulator element and the product wraps modulo 2^(wide size), with no saturation.
- R7: Every element of all four rows is updated by every operation.
- R8: An operation is accepted when `in_valid` and `in_ready` are both high. Its result appears on `acc_out` with `out_valid` high from the next cycle on.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and `acc_out` hold.
- R10: A synchronous active-high `rst` clears `out_valid` and `acc_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| mode | input | 1 | 0: 8→32 bit, 1: 16→64 bit |
| idx | input | 4 | Multiplier element position per segment |
| src_a | input | VL | Narrow multiplicand vector |
| src_b | input | VL | Vector holding the indexed multiplier |
| acc_in | input | 4*VL | Four accumulator rows |
| out_valid | output | 1 | Result held on acc_out |
| out_ready | input | 1 | Consumer takes the result |
| acc_out | output | 4*VL | Four updated accumulator rows |

## Verification
Acceptance of a new operation can coincide with the consumer draining the previous result, because `in_ready` follows `out_ready` in the same cycle. The bench provokes this with back-to-back operations while `out_ready` is held high, and also with a release from a stall while the next operation is already waiting. It judges the overlap by checking that each consecutive result matches its own reference value in the cycle it appears, so that no result is lost, duplicated or mixed with its neighbour.

// File: rtl/qmac_pkg.sv
package qmac_pkg;
  typedef enum logic {
    QM_B2W = 1'b0,
    QM_H2D = 1'b1
  } qmac_mode_e;

  localparam int unsigned SEG_W = 128;
  localparam int unsigned ROWS  = 4;
endpackage

// File: rtl/qmac_bcast.sv
module qmac_bcast
  import qmac_pkg::*;
#(
  parameter int unsigned VL = 128
) (
  input  logic [VL-1:0]            src_b,
  input  logic [3:0]               idx,
  output logic [(VL/SEG_W)*8-1:0]  b8,
  output logic [(VL/SEG_W)*16-1:0] b16
);
  localparam int unsigned NSEG = VL / SEG_W;

  logic [6:0] off8;
  logic [6:0] off16;
  assign off8  = {idx, 3'b000};
  assign off16 = {idx[2:0], 4'b0000};

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam int unsigned BASE = s * SEG_W;
    assign b8[s*8 +: 8]   = src_b[BASE + int'(off8)  +: 8];
    assign b16[s*16 +: 16] = src_b[BASE + int'(off16) +: 16];
  end
endmodule

// File: rtl/qmac_row.sv
module qmac_row
  import qmac_pkg::*;
#(
  parameter int unsigned VL  = 128,
  parameter int unsigned ROW = 0
) (
  input  qmac_mode_e               mode,
  input  logic [VL-1:0]            src_a,
  input  logic [(VL/SEG_W)*8-1:0]  b8,
  input  logic [(VL/SEG_W)*16-1:0] b16,
  input  logic [VL-1:0]            acc_row,
  output logic [VL-1:0]            res_row
);
  localparam int unsigned E32 = VL / 32;
  localparam int unsigned E64 = VL / 64;
  localparam int unsigned PER_SEG32 = SEG_W / 32;
  localparam int unsigned PER_SEG64 = SEG_W / 64;

  logic [VL-1:0] r8;
  logic [VL-1:0] r16;

  for (genvar e = 0; e < E32; e++) begin : g_w32
    localparam int unsigned AOFS = (4*e + ROW) * 8;
    localparam int unsigned SEG  = e / PER_SEG32;
    logic [7:0]         na;
    logic [7:0]         nb;
    logic signed [15:0] xa;
    logic signed [15:0] xb;
    logic signed [15:0] prod;
    assign na   = src_a[AOFS +: 8];
    assign nb   = b8[SEG*8 +: 8];
    assign xa   = $signed({{8{na[7]}}, na});
    assign xb   = $signed({{8{nb[7]}}, nb});
    assign prod = xa * xb;
    assign r8[e*32 +: 32] = acc_row[e*32 +: 32] + {{16{prod[15]}}, prod};
  end

  for (genvar e = 0; e < E64; e++) begin : g_w64
    localparam int unsigned AOFS = (4*e + ROW) * 16;
    localparam int unsigned SEG  = e / PER_SEG64;
    logic [15:0]        na;
    logic [15:0]        nb;
    logic signed [31:0] xa;
    logic signed [31:0] xb;
    logic signed [31:0] prod;
    assign na   = src_a[AOFS +: 16];
    assign nb   = b16[SEG*16 +: 16];
    assign xa   = $signed({{16{na[15]}}, na});
    assign xb   = $signed({{16{nb[15]}}, nb});
    assign prod = xa * xb;
    assign r16[e*64 +: 64] = acc_row[e*64 +: 64] + {{32{prod[31]}}, prod};
  end

  assign res_row = (mode == QM_H2D) ? r16 : r8;
endmodule

// File: rtl/qmac_quad.sv
module qmac_quad
  import qmac_pkg::*;
#(
  parameter int unsigned VL = 128
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 mode,
  input  logic [3:0]           idx,
  input  logic [VL-1:0]        src_a,
  input  logic [VL-1:0]        src_b,
  input  logic [ROWS*VL-1:0]   acc_in,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [ROWS*VL-1:0]   acc_out
);
  localparam int unsigned NSEG = VL / SEG_W;

  qmac_mode_e                 mode_e;
  logic [NSEG*8-1:0]          b8;
  logic [NSEG*16-1:0]         b16;
  logic [ROWS*VL-1:0]         acc_nxt;
  logic                       take;

  assign mode_e   = qmac_mode_e'(mode);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  qmac_bcast #(.VL(VL)) bcast_i (
    .src_b (src_b),
    .idx   (idx),
    .b8    (b8),
    .b16   (b16)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    qmac_row #(.VL(VL), .ROW(r)) row_i (
      .mode    (mode_e),
      .src_a   (src_a),
      .b8      (b8),
      .b16     (b16),
      .acc_row (acc_in[r*VL +: VL]),
      .res_row (acc_nxt[r*VL +: VL])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      acc_out   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      acc_out   <= acc_nxt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/qmac_quad_chk.sv
module qmac_quad_chk #(
  parameter int unsigned VL = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              mode,
  input logic [3:0]        idx,
  input logic [VL-1:0]     src_a,
  input logic [VL-1:0]     src_b,
  input logic [4*VL-1:0]   acc_in,
  input logic              out_valid,
  input logic              out_ready,
  input logic [4*VL-1:0]   acc_out
);
  a_r8_result_follows_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  a_r9_ready_when_empty: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(acc_out)));

  a_r9_no_accept_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  a_r5_zero_multiplicand: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && src_a == '0) |=> (acc_out == $past(acc_in)));

  a_r10_reset_clears: assert property (@(posedge clk)
    $fell(rst) |-> (!out_valid && acc_out == '0));
endmodule

bind qmac_quad qmac_quad_chk #(.VL(VL)) chk_i (.*);

// File: tb/qmac_quad_tb_top.sv
`timescale 1ns/1ps
module qmac_quad_tb_top;
  localparam int VL = 256;

  logic            clk = 1'b0;
  logic            rst;
  logic            in_valid;
  logic            in_ready;
  logic            mode;
  logic [3:0]      idx;
  logic [VL-1:0]   src_a;
  logic [VL-1:0]   src_b;
  logic [4*VL-1:0] acc_in;
  logic            out_valid;
  logic            out_ready;
  logic [4*VL-1:0] acc_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  qmac_quad #(.VL(VL)) dut_i (.*);

  task automatic chk(input string req, input logic [4*VL-1:0] act, input logic [4*VL-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4*VL-1:0] model(input logic m, input logic [3:0] ix,
      input logic [VL-1:0] a, input logic [VL-1:0] b, input logic [4*VL-1:0] acc);
    logic [4*VL-1:0] res;
    res = acc;
    for (int r = 0; r < 4; r++) begin
      if (!m) begin
        for (int e = 0; e < VL/32; e++) begin
          logic signed [63:0] pa, pb, p;
          pa = 64'($signed(a[(4*e+r)*8 +: 8]));
          pb = 64'($signed(b[((e/4)*16 + int'(ix))*8 +: 8]));
          p = pa * pb;
          res[r*VL + e*32 +: 32] = acc[r*VL + e*32 +: 32] + p[31:0];
        end
      end else begin
        for (int e = 0; e < VL/64; e++) begin
          logic signed [63:0] pa, pb, p;
          pa = 64'($signed(a[(4*e+r)*16 +: 16]));
          pb = 64'($signed(b[((e/2)*8 + int'(ix[2:0]))*16 +: 16]));
          p = pa * pb;
          res[r*VL + e*64 +: 64] = acc[r*VL + e*64 +: 64] + p;
        end
      end
    end
    return res;
  endfunction

  function automatic logic [4*VL-1:0] rnd_wide();
    logic [4*VL-1:0] v;
    for (int k = 0; k < 4*VL/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic drive(input logic m, input logic [3:0] ix, input logic [VL-1:0] a,
      input logic [VL-1:0] b, input logic [4*VL-1:0] acc);
    mode = m; idx = ix; src_a = a; src_b = b; acc_in = acc; in_valid = 1'b1;
  endtask

  // single operation with out_ready high; returns result seen one cycle later
  task automatic run_op(input logic m, input logic [3:0] ix, input logic [VL-1:0] a,
      input logic [VL-1:0] b, input logic [4*VL-1:0] acc, output logic [4*VL-1:0] got);
    @(negedge clk);
    out_ready = 1'b1;
    drive(m, ix, a, b, acc);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 out_valid after accept", {1023'b0, out_valid}, {1023'b0, 1'b1});
    got = acc_out;
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    mode = 1'b0; idx = '0; src_a = '0; src_b = '0; acc_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R10 out_valid cleared", {1023'b0, out_valid}, '0);
    chk("R10 acc_out cleared", acc_out, '0);
    chk("R9 in_ready while empty", {1023'b0, in_ready}, {1023'b0, 1'b1});
  endtask

  task automatic t_lane_map();
    logic [VL-1:0] a, b; logic [4*VL-1:0] got, exp;
    for (int k = 0; k < VL/8; k++) a[k*8 +: 8] = 8'(k);
    for (int k = 0; k < VL/8; k++) b[k*8 +: 8] = 8'd1;
    run_op(1'b0, 4'd0, a, b, '0, got);
    // R2: row 2 element 3 holds byte 14, row 1 element 5 holds byte 21
    chk("R2 row2 elem3", {992'b0, got[2*VL + 3*32 +: 32]}, {992'b0, 32'd14});
    chk("R2 row1 elem5", {992'b0, got[1*VL + 5*32 +: 32]}, {992'b0, 32'd21});
    exp = model(1'b0, 4'd0, a, b, '0);
    chk("R2 R7 full lane map", got, exp);
  endtask

  task automatic t_broadcast();
    logic [VL-1:0] a, b; logic [4*VL-1:0] got;
    for (int k = 0; k < VL/8; k++) a[k*8 +: 8] = 8'd1;
    for (int k = 0; k < VL/8; k++) b[k*8 +: 8] = 8'(k);
    run_op(1'b0, 4'd5, a, b, '0, got);
    chk("R3 seg0 elem0 idx5", {992'b0, got[0 +: 32]}, {992'b0, 32'd5});
    chk("R3 seg1 elem4 idx5", {992'b0, got[3*VL + 4*32 +: 32]}, {992'b0, 32'd21});
    run_op(1'b0, 4'd15, a, b, '0, got);
    chk("R4 byte idx15 seg1", {992'b0, got[7*32 +: 32]}, {992'b0, 32'd31});
  endtask

  task automatic t_signed_wrap();
    logic [VL-1:0] a, b; logic [4*VL-1:0] acc, got;
    a = {(VL/8){8'h80}}; b = {(VL/8){8'h80}};
    run_op(1'b0, 4'd3, a, b, '0, got);
    chk("R5 -128*-128", {992'b0, got[0 +: 32]}, {992'b0, 32'h0000_4000});
    a = {(VL/8){8'hFF}}; b = {(VL/8){8'h02}};
    run_op(1'b0, 4'd0, a, b, '0, got);
    chk("R5 -1*2", {992'b0, got[VL +: 32]}, {992'b0, 32'hFFFF_FFFE});
    a = {(VL/8){8'h01}}; b = {(VL/8){8'h01}}; acc = {(4*VL/32){32'h7FFF_FFFF}};
    run_op(1'b0, 4'd0, a, b, acc, got);
    chk("R6 32-bit wrap", {992'b0, got[0 +: 32]}, {992'b0, 32'h8000_0000});
    a = {(VL/16){16'h0001}}; b = {(VL/16){16'hFFFF}}; acc = '0;
    run_op(1'b1, 4'd0, a, b, acc, got);
    chk("R5 R6 64-bit -1 wraps", {960'b0, got[0 +: 64]}, {960'b0, 64'hFFFF_FFFF_FFFF_FFFF});
  endtask

  task automatic t_half_mode();
    logic [VL-1:0] a, b; logic [4*VL-1:0] acc, got, exp;
    for (int k = 0; k < VL/16; k++) a[k*16 +: 16] = 16'(k + 1);
    for (int k = 0; k < VL/16; k++) b[k*16 +: 16] = 16'(100 * k);
    run_op(1'b1, 4'd3, a, b, '0, got);
    // R1 R3: row 0 elem 2 (seg 1) = half 8 (=9) * half 11 (=1100)
    chk("R1 R3 half row0 elem2", {960'b0, got[2*64 +: 64]}, {960'b0, 64'd9900});
    got = '0;
    run_op(1'b1, 4'hB, a, b, '0, got);
    exp = model(1'b1, 4'd3, a, b, '0);
    chk("R4 idx bit3 ignored in half mode", got, exp);
    a = rnd_wide(); b = rnd_wide(); acc = rnd_wide();
    run_op(1'b1, 4'd6, a, b, acc, got);
    chk("R1 R7 half random", got, model(1'b1, 4'd6, a, b, acc));
  endtask

  task automatic t_random_byte();
    logic [VL-1:0] a, b; logic [4*VL-1:0] acc, got;
    for (int n = 0; n < 4; n++) begin
      logic [3:0] ix;
      a = rnd_wide(); b = rnd_wide(); acc = rnd_wide(); ix = 4'($urandom);
      run_op(1'b0, ix, a, b, acc, got);
      chk("R1 R5 R6 byte random", got, model(1'b0, ix, a, b, acc));
    end
  endtask

  task automatic t_back_to_back();
    logic [VL-1:0] a0, b0, a1, b1; logic [4*VL-1:0] c0, c1;
    a0 = rnd_wide(); b0 = rnd_wide(); c0 = rnd_wide();
    a1 = rnd_wide(); b1 = rnd_wide(); c1 = rnd_wide();
    @(negedge clk);
    out_ready = 1'b1;
    drive(1'b0, 4'd9, a0, b0, c0);
    @(negedge clk);
    chk("R8 first of pair", acc_out, model(1'b0, 4'd9, a0, b0, c0));
    chk("R9 ready while draining", {1023'b0, in_ready}, {1023'b0, 1'b1});
    drive(1'b1, 4'd2, a1, b1, c1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 second of pair", acc_out, model(1'b1, 4'd2, a1, b1, c1));
    @(negedge clk);
    chk("R8 valid drops once drained", {1023'b0, out_valid}, '0);
  endtask

  task automatic t_stall();
    logic [VL-1:0] a0, b0, a1, b1; logic [4*VL-1:0] c0, c1, e0;
    a0 = rnd_wide(); b0 = rnd_wide(); c0 = rnd_wide();
    a1 = rnd_wide(); b1 = rnd_wide(); c1 = rnd_wide();
    e0 = model(1'b0, 4'd1, a0, b0, c0);
    @(negedge clk);
    out_ready = 1'b0;
    drive(1'b0, 4'd1, a0, b0, c0);
    @(negedge clk);
    drive(1'b0, 4'd4, a1, b1, c1);
    chk("R9 in_ready low when stalled", {1023'b0, in_ready}, '0);
    repeat (3) @(negedge clk);
    chk("R9 result held during stall", acc_out, e0);
    chk("R9 valid held during stall", {1023'b0, out_valid}, {1023'b0, 1'b1});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 waiting op taken on release", acc_out, model(1'b0, 4'd4, a1, b1, c1));
    @(negedge clk);
    chk("R9 no duplicate", {1023'b0, out_valid}, '0);
  endtask

  initial begin
    t_reset();
    t_lane_map();
    t_broadcast();
    t_signed_wrap();
    t_half_mode();
    t_random_byte();
    t_back_to_back();
    t_stall();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 reset after traffic", acc_out, '0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule